// File: doc/BRIEF.md
# Copyback Data Cache with Push Buffer

This block is a four-way set-associative, physically tagged, write-back data cache. The CPU gives the untranslated low address bits, which pick the set and the longword within the line. In the same cycle it gives the translated physical tag. The tag is compared against every way of the chosen set. Read hits return one 32-bit longword. Write hits merge the enabled bytes into the cached longword and mark the line dirty.

On a miss a victim way is chosen. If the victim is valid and dirty, its four longwords are copied into an internal push buffer. The new line is then fetched as a four-beat burst. Only after the fill completes is the buffered line written out as a four-beat burst. A separate push command, given a set and a way, forces a dirty line out and clears its dirty state. Memory traffic uses one valid/ready channel, with one handshake per beat.

Top module: `copyback_dcache`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_ack` and `mem_valid` are low and every line is invalid, so the first access to any address misses.
- R2: An accepted read that hits raises `cpu_ack` in the next cycle, with `cpu_rdata` holding the addressed longword, and causes no memory traffic.
- R3: An accepted write that hits changes only the bytes whose `cpu_be` bit is set (bit b covers data bits 8b+7:8b) in the addressed longword, and marks the line dirty.
- R4: A fill is a four-beat read burst. The first beat addresses longword 0 of the line and each later beat adds 4 to the address. `mem_addr` and `mem_we` hold steady while `mem_ready` is low.
- R5: When the victim is valid and dirty, all four fill beats complete before a four-beat write burst carries the old line's data to the old line's address.
- R6: A clean or invalid victim is overwritten with no write burst.
- R7: The victim is the lowest-numbered invalid way of the set. If all ways are valid, it is the way named by a per-set round-robin pointer, which then advances by one.
- R8: A write miss fills the line, merges the write data into the filled longword, leaves the line dirty, and acknowledges once the fill is done.
- R9: An accepted push of a valid dirty line writes its four longwords back as a burst and clears its dirty state. A push of a clean or invalid line causes no traffic.
- R10: `cpu_busy` is high during every fill and write-back, and memory traffic occurs only while it is high. Requests are taken only while it is low. A push request in the same cycle as a CPU request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, taken when not busy |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_lidx | input | 6 | Untranslated index: [5:2] set, [1:0] longword |
| cpu_ptag | input | 24 | Translated physical tag |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_busy | output | 1 | Fill or write-back in progress |
| cpu_ack | output | 1 | Access completed (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on reads |
| push_req | input | 1 | Force write-back of a line |
| push_set | input | 4 | Set to push |
| push_way | input | 2 | Way to push |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address {tag, set, longword, 00} |
| mem_wdata | output | 32 | Write beat data |
| mem_ready | input | 1 | Beat accepted or read data present |
| mem_rdata | input | 32 | Read beat data |

## Verification
The hardest case to reach is a round-robin replacement whose outcome can be seen only at the ports. The bench fills one set through its invalid ways, which leaves the pointer at zero. It then dirties way 0 and runs a series of misses and hits in that set. Each access records the number of read and write beats, and the bench predicts whether each tag hits from the pointer position it expects. One set of misses evicts a dirty line, and its logged beats must show the fill before the write-back. Pushes issued in the same cycle as a CPU read, and pushes of clean lines, must produce no beats. A final sweep pushes every line and compares the whole memory image with a reference image.

// File: rtl/copyback_dcache.sv
module copyback_dcache #(
  parameter int TAG_W = 24,
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic                     cpu_we,
  input  logic [$clog2(SETS)+$clog2(WORDS)-1:0] cpu_lidx,
  input  logic [TAG_W-1:0]         cpu_ptag,
  input  logic [3:0]               cpu_be,
  input  logic [31:0]              cpu_wdata,
  output logic                     cpu_busy,
  output logic                     cpu_ack,
  output logic [31:0]              cpu_rdata,
  input  logic                     push_req,
  input  logic [$clog2(SETS)-1:0]  push_set,
  input  logic [$clog2(WAYS)-1:0]  push_way,
  output logic                     mem_valid,
  output logic                     mem_we,
  output logic [TAG_W+$clog2(SETS)+$clog2(WORDS)+1:0] mem_addr,
  output logic [31:0]              mem_wdata,
  input  logic                     mem_ready,
  input  logic [31:0]              mem_rdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int WORD_W = $clog2(WORDS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int AW = TAG_W + SET_W + WORD_W + 2;

  typedef enum logic [1:0] {IDLE, FILL, DRAIN} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [31:0]       dat_q [SETS][WAYS][WORDS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   dty_q [SETS];
  logic [WAY_W-1:0]  rr_q  [SETS];

  logic [SET_W-1:0]  set_r, pb_set;
  logic [WORD_W-1:0] wrd_r, cnt_q;
  logic [TAG_W-1:0]  tag_r, pb_tag;
  logic [WAY_W-1:0]  way_r;
  logic              we_r, pend_q;
  logic [3:0]        be_r;
  logic [31:0]       wd_r;
  logic [31:0]       pb_dat [WORDS];

  wire [SET_W-1:0]  c_set = cpu_lidx[SET_W+WORD_W-1:WORD_W];
  wire [WORD_W-1:0] c_wrd = cpu_lidx[WORD_W-1:0];

  logic hit, free;
  logic [WAY_W-1:0] hway, fway, vway;
  always_comb begin
    hit = 1'b0; hway = '0; free = 1'b0; fway = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[c_set][w] && tag_q[c_set][w] == cpu_ptag) begin
        hit = 1'b1; hway = WAY_W'(w);
      end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[c_set][w]) begin
        free = 1'b1; fway = WAY_W'(w);
      end
    vway = free ? fway : rr_q[c_set];
  end

  function automatic logic [31:0] merge(input logic [3:0] be, input logic [31:0] nw, input logic [31:0] old);
    for (int b = 0; b < 4; b++) merge[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
  endfunction

  assign cpu_busy  = st != IDLE;
  assign mem_valid = st != IDLE;
  assign mem_we    = st == DRAIN;
  assign mem_addr  = mem_we ? {pb_tag, pb_set, cnt_q, 2'b00} : {tag_r, set_r, cnt_q, 2'b00};
  assign mem_wdata = pb_dat[cnt_q];

  wire beat   = mem_valid && mem_ready;
  wire last   = beat && cnt_q == WORD_W'(WORDS - 1);
  wire accept = st == IDLE && cpu_req;
  wire pacc   = st == IDLE && !cpu_req && push_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt_q <= '0; cpu_ack <= 1'b0; pend_q <= 1'b0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0; dty_q[s] <= '0; rr_q[s] <= '0;
      end
    end else begin
      cpu_ack <= 1'b0;
      case (st)
        IDLE: begin
          if (accept && hit) begin
            cpu_ack <= 1'b1;
            if (cpu_we) begin
              dat_q[c_set][hway][c_wrd] <= merge(cpu_be, cpu_wdata, dat_q[c_set][hway][c_wrd]);
              dty_q[c_set][hway] <= 1'b1;
            end else
              cpu_rdata <= dat_q[c_set][hway][c_wrd];
          end else if (accept) begin
            set_r <= c_set; wrd_r <= c_wrd; tag_r <= cpu_ptag; way_r <= vway;
            we_r <= cpu_we; be_r <= cpu_be; wd_r <= cpu_wdata;
            if (vld_q[c_set][vway] && dty_q[c_set][vway]) begin
              for (int k = 0; k < WORDS; k++) pb_dat[k] <= dat_q[c_set][vway][k];
              pb_tag <= tag_q[c_set][vway]; pb_set <= c_set; pend_q <= 1'b1;
            end
            vld_q[c_set][vway] <= 1'b0;
            if (!free) rr_q[c_set] <= rr_q[c_set] + 1'b1;
            cnt_q <= '0;
            st <= FILL;
          end else if (pacc && vld_q[push_set][push_way] && dty_q[push_set][push_way]) begin
            for (int k = 0; k < WORDS; k++) pb_dat[k] <= dat_q[push_set][push_way][k];
            pb_tag <= tag_q[push_set][push_way]; pb_set <= push_set;
            dty_q[push_set][push_way] <= 1'b0;
            cnt_q <= '0;
            st <= DRAIN;
          end
        end
        FILL: if (beat) begin
          dat_q[set_r][way_r][cnt_q] <= (we_r && cnt_q == wrd_r) ? merge(be_r, wd_r, mem_rdata) : mem_rdata;
          if (cnt_q == wrd_r) cpu_rdata <= mem_rdata;
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            tag_q[set_r][way_r] <= tag_r;
            vld_q[set_r][way_r] <= 1'b1;
            dty_q[set_r][way_r] <= we_r;
            cpu_ack <= 1'b1;
            pend_q <= 1'b0;
            st <= pend_q ? DRAIN : IDLE;
          end
        end
        DRAIN: if (beat) begin
          cnt_q <= cnt_q + 1'b1;
          if (last) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_checks.sv
module dcache_checks #(
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_busy,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [WORD_W-1:0] mem_word
);
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_word) && $stable(mem_we));

  a_r4_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_word != {WORD_W{1'b1}} |=> mem_valid && mem_word == $past(mem_word) + 1'b1);

  a_r4_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) || $rose(mem_we) |-> mem_word == '0);

  a_r5_fill_before_drain: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |=> !mem_valid || mem_we);

  a_r10_traffic_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_busy |-> !mem_valid);
endmodule

bind copyback_dcache dcache_checks #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_busy(cpu_busy), .mem_valid(mem_valid),
  .mem_we(mem_we), .mem_ready(mem_ready), .mem_word(mem_addr[WORD_W+1:2]));

// File: tb/copyback_dcache_test.sv
module copyback_dcache_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cpu_req = 0, cpu_we = 0, push_req = 0, mem_ready = 0;
  logic [5:0] cpu_lidx = 0;
  logic [23:0] cpu_ptag = 0;
  logic [3:0] cpu_be = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata, mem_wdata, mem_rdata;
  logic [3:0] push_set = 0;
  logic [1:0] push_way = 0;
  logic cpu_busy, cpu_ack, mem_valid, mem_we;
  logic [31:0] mem_addr;

  copyback_dcache uut (.*);

  logic [31:0] mem_m [2048];
  logic [31:0] gold [2048];
  assign mem_rdata = mem_m[mem_addr[12:2]];

  int checks = 0, errors = 0, nrd = 0, nwr = 0, busy_viol = 0, cyc = 0;
  logic log_we [$];
  logic [31:0] log_a [$];
  logic [32:0] exp_q [$];
  string req_q [$];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", r, act, exp); end
  endtask

  function automatic int ix(input int t, input int s, input int w);
    return t * 64 + s * 4 + w;
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_ready <= (cyc % 3) != 0;
    if (cpu_ack) begin
      if (exp_q.size() == 0) chk(0, "R2 unexpected ack", 1, 0);
      else begin
        logic [32:0] e; string r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        if (e[32]) chk(cpu_rdata == e[31:0], r, cpu_rdata, e[31:0]);
      end
    end
  end

  always @(posedge clk) if (rst_n && mem_valid) begin
    if (!cpu_busy) busy_viol++;
    if (mem_ready) begin
      if (mem_we) begin mem_m[mem_addr[12:2]] = mem_wdata; nwr++; end
      else nrd++;
      log_we.push_back(mem_we); log_a.push_back(mem_addr);
    end
  end

  task automatic wait_idle;
    @(negedge clk);
    while (cpu_busy) @(negedge clk);
  endtask

  task automatic clr;
    wait_idle; nrd = 0; nwr = 0; log_we.delete(); log_a.delete();
  endtask

  task automatic rd(input int t, input int s, input int w, input string r, input bit with_push = 0);
    wait_idle;
    cpu_req = 1; cpu_we = 0; cpu_lidx = {4'(s), 2'(w)}; cpu_ptag = 24'(t);
    push_req = with_push; push_set = 4'(s); push_way = 0;
    exp_q.push_back({1'b1, gold[ix(t, s, w)]}); req_q.push_back(r);
    @(posedge clk); #1 cpu_req = 0; push_req = 0;
  endtask

  task automatic wr(input int t, input int s, input int w, input logic [3:0] be, input logic [31:0] d, input string r);
    wait_idle;
    for (int b = 0; b < 4; b++) if (be[b]) gold[ix(t, s, w)][8*b +: 8] = d[8*b +: 8];
    cpu_req = 1; cpu_we = 1; cpu_lidx = {4'(s), 2'(w)}; cpu_ptag = 24'(t); cpu_be = be; cpu_wdata = d;
    exp_q.push_back({1'b0, 32'h0}); req_q.push_back(r);
    @(posedge clk); #1 cpu_req = 0; cpu_we = 0;
  endtask

  task automatic push(input int s, input int w);
    wait_idle;
    push_req = 1; push_set = 4'(s); push_way = 2'(w);
    @(posedge clk); #1 push_req = 0;
  endtask

  task automatic traffic(input string r, input int er, input int ew);
    wait_idle; @(negedge clk);
    chk(nrd == er, {r, " read beats"}, nrd, er);
    chk(nwr == ew, {r, " write beats"}, nwr, ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin mem_m[i] = 32'h5A000000 ^ (i * 32'h00010203); gold[i] = mem_m[i]; end
    repeat (3) @(posedge clk);
    #1;
    chk(!cpu_busy && !cpu_ack && !mem_valid, "R1 reset outputs", {cpu_busy, cpu_ack, mem_valid}, 0);
    rst_n = 1;

    clr; rd(0, 0, 2, "R1 R4 first read"); traffic("R1 first access misses", 4, 0);
    for (int k = 0; k < 4; k++) chk(log_a[k] == 32'(ix(0, 0, k) * 4), "R4 burst address order", log_a[k], 32'(ix(0, 0, k) * 4));

    clr; rd(0, 0, 1, "R2 read hit data"); traffic("R2 hit no traffic", 0, 0);
    clr; wr(0, 0, 1, 4'b0010, 32'h0000AB00, "R3 write hit"); rd(0, 0, 1, "R3 byte merge"); traffic("R3 write hit no traffic", 0, 0);

    for (int t = 1; t < 4; t++) begin clr; rd(t, 0, 0, "R7 fill free way"); traffic("R6 invalid victim", 4, 0); end
    clr; rd(0, 0, 3, "R7 invalid way chosen first"); traffic("R7 tag0 kept", 0, 0);

    clr; rd(4, 0, 0, "R5 dirty victim read"); traffic("R5 dirty eviction", 4, 4);
    for (int k = 0; k < 8; k++) chk(log_we[k] == (k >= 4), "R5 fill precedes write-back", log_we[k], k >= 4);
    chk(log_a[4] == 32'(ix(0, 0, 0) * 4), "R5 write-back address", log_a[4], 32'(ix(0, 0, 0) * 4));
    chk(mem_m[ix(0, 0, 1)] == gold[ix(0, 0, 1)], "R5 written data", mem_m[ix(0, 0, 1)], gold[ix(0, 0, 1)]);

    clr; rd(5, 0, 0, "R6 clean victim"); traffic("R6 clean victim no write", 4, 0);
    clr; rd(3, 0, 2, "R7 way3 kept"); traffic("R7 way3 hit", 0, 0);
    clr; rd(1, 0, 0, "R7 rr way2"); traffic("R7 tag1 missed", 4, 0);
    clr; rd(2, 0, 0, "R7 rr way3"); traffic("R7 tag2 missed", 4, 0);
    clr; rd(4, 0, 1, "R7 tag4 kept"); traffic("R7 tag4 hit", 0, 0);
    clr; rd(5, 0, 1, "R7 tag5 kept"); traffic("R7 tag5 hit", 0, 0);
    clr; rd(3, 0, 0, "R7 wrap to way0"); traffic("R7 tag3 evicts way0", 4, 0);

    clr; wr(6, 1, 3, 4'b1111, 32'hDEADBEEF, "R8 write miss"); traffic("R8 write miss fills", 4, 0);
    clr; rd(6, 1, 3, "R8 merged after fill"); traffic("R8 hit after allocate", 0, 0);
    wr(6, 1, 0, 4'b1000, 32'h77000000, "R3 write upper byte");

    clr; push(1, 0); traffic("R9 push dirty line", 0, 4);
    for (int k = 0; k < 4; k++) chk(mem_m[ix(6, 1, k)] == gold[ix(6, 1, k)], "R9 pushed data", mem_m[ix(6, 1, k)], gold[ix(6, 1, k)]);
    clr; push(1, 0); traffic("R9 dirty cleared", 0, 0);
    clr; push(2, 0); traffic("R9 invalid line push", 0, 0);

    clr; wr(3, 0, 0, 4'b0101, 32'h00CC00DD, "R3 dirty way0");
    rd(3, 0, 0, "R10 read with push", 1); traffic("R10 simultaneous push ignored", 0, 0);
    clr; push(0, 0); traffic("R9 push after ignore", 0, 4);

    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) push(s, w);
    wait_idle;
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) if (mem_m[i] != gold[i]) bad++;
      chk(bad == 0, "R5 R9 final memory image", bad, 0);
    end
    chk(exp_q.size() == 0, "R2 all acks seen", exp_q.size(), 0);
    chk(busy_viol == 0, "R10 busy during traffic", busy_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule